// File: doc/BRIEF.md
# Windowed Maximum Search Memory

This block is a small on-chip memory that holds a two-dimensional array of unsigned words and, besides ordinary single-word writes and reads, can answer one extra question in a single access. The question is: within the 3x3 neighbourhood centred on a given element, which stored value is the largest, and where is it? The host supplies a row and column for the centre together with a search command. One clock later the memory returns the winning value and its absolute row and column in the array.

Internally the array is split across three row banks. Array row r lives in bank r mod 3, so the three rows of any window always fall in three different banks and can be read together. Each bank is further split into three column lanes by column mod 3, so one bank delivers three neighbouring words of a row in the same cycle. Each bank reduces its three words to a row winner with a bit-serial elimination comparator. A second comparator of the same kind then picks the window winner from the three row winners. Window positions that fall outside the array are excluded from the competition.

Top module: `win_max_ram`

## Requirements
- R1: On cmd = 1 (write), wdata is stored at (row_i, col_i). On cmd = 2 (read), rd_data returns the word stored at (row_i, col_i) and rd_valid is high in the cycle after the command. A write is visible to a read issued in the very next cycle.
- R2: On cmd = 3 (search), with a centre inside the array, win_max holds the largest unsigned value among the in-range positions of rows row_i-1..row_i+1 and columns col_i-1..col_i+1. win_valid is high in the cycle after the command.
- R3: win_row and win_col give the absolute array location of the value reported in win_max. That location lies inside the searched window.
- R4: When several in-range positions hold the maximum, the one in the lowest row is reported. Among those, the one in the lowest column is reported.
- R5: Positions outside the array never win, even when every in-range value is zero. A reported location always satisfies win_row < ROWS and win_col < COLS.
- R6: A new command may be issued every cycle. Back-to-back searches each produce their own result exactly one cycle after their own command.
- R7: After reset, and in the cycle after a no-op (cmd = 0) or a write, rd_valid and win_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | 0 no-op, 1 write, 2 read, 3 window search |
| row_i | input | $clog2(ROWS) | Row of the addressed word or window centre |
| col_i | input | $clog2(COLS) | Column of the addressed word or window centre |
| wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Word read |
| win_valid | output | 1 | Search result valid |
| win_max | output | DATA_W | Largest value in the window |
| win_row | output | $clog2(ROWS) | Row of that value |
| win_col | output | $clog2(COLS) | Column of that value |

## Verification
Every result is due exactly one clock after its command, because the memory reads combinationally and both the read and search results pass through one output register. The bench drives a command on a falling edge and samples the outputs on the next falling edge. By then the single rising edge in between has captured the result. The next command is driven at that same falling edge, so back-to-back searches are checked each against its own expected value. A reference model of the array, held in the bench, gives the expected maximum and location for every window, using a row-major strict-greater scan that encodes the tie and edge rules.

// File: rtl/wmr_pkg.sv
package wmr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_READ   = 2'd2,
    CMD_SEARCH = 2'd3
  } wmr_cmd_e;

  localparam int WIN = 3;
endpackage

// File: rtl/wmr_compete.sv
module wmr_compete #(
  parameter int N = 3,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [W-1:0]  val [N],
  input  logic [N-1:0]  ok,
  output logic [W-1:0]  best,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N-1:0] alive;
  logic [N-1:0] ones;

  // bit-serial elimination: from the MSB down, drop survivors with a 0 while any has a 1
  always_comb begin
    alive = ok;
    for (int b = W - 1; b >= 0; b--) begin
      for (int i = 0; i < N; i++) ones[i] = alive[i] & val[i][b];
      if (|ones) alive = ones;
    end
    idx  = '0;
    best = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (alive[i]) begin
        idx  = IW'(i);
        best = val[i];
      end
    end
    any = |ok;
  end
endmodule

// File: rtl/wmr_row_bank.sv
module wmr_row_bank #(
  parameter int DATA_W = 8,
  parameter int COLS   = 16,
  parameter int BR     = 4,
  localparam int LD    = (COLS + 2) / 3,
  localparam int DEPTH = BR * LD,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BRW   = (BR > 1) ? $clog2(BR) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [1:0]        wlane,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BRW-1:0]    brow,
  input  logic              row_ok,
  input  logic [CW-1:0]     col_c,
  output logic [DATA_W-1:0] row_max,
  output logic [1:0]        row_off,
  output logic              row_any,
  output logic [DATA_W-1:0] mid_val
);
  import wmr_pkg::*;

  int                cm;
  int                acol [WIN];
  int                lane_of [WIN];
  logic [WIN-1:0]    col_in;
  logic [WIN-1:0]    cok;
  logic [AW-1:0]     raddr [WIN];
  logic [DATA_W-1:0] lv    [WIN];
  logic [DATA_W-1:0] vals  [WIN];

  // address generation: window column j sits in lane (col mod 3)
  always_comb begin
    cm = int'(col_c) % 3;
    for (int l = 0; l < WIN; l++) raddr[l] = '0;
    for (int j = 0; j < WIN; j++) begin
      acol[j]    = int'(col_c) - 1 + j;
      lane_of[j] = (cm + j + 2) % 3;
      col_in[j]  = (acol[j] >= 0) && (acol[j] < COLS);
      cok[j]     = row_ok && col_in[j];
      if (col_in[j])
        raddr[lane_of[j]] = AW'(int'(brow) * LD + acol[j] / 3);
    end
  end

  // one simple dual-port memory per column lane
  for (genvar l = 0; l < WIN; l++) begin : g_lane
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wlane == 2'(l))) mem[waddr] <= wdata;
    end
    assign lv[l] = mem[raddr[l]];
  end

  always_comb begin
    for (int j = 0; j < WIN; j++) vals[j] = lv[lane_of[j]];
  end

  assign mid_val = vals[1];

  wmr_compete #(.N(WIN), .W(DATA_W)) u_row_cmp (
    .val  (vals),
    .ok   (cok),
    .best (row_max),
    .idx  (row_off),
    .any  (row_any)
  );
endmodule

// File: rtl/win_max_ram.sv
module win_max_ram #(
  parameter int DATA_W = 8,
  parameter int ROWS   = 12,
  parameter int COLS   = 16,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic [RW-1:0]     row_i,
  input  logic [CW-1:0]     col_i,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              win_valid,
  output logic [DATA_W-1:0] win_max,
  output logic [RW-1:0]     win_row,
  output logic [CW-1:0]     win_col
);
  import wmr_pkg::*;

  localparam int BR    = (ROWS + 2) / 3;
  localparam int LD    = (COLS + 2) / 3;
  localparam int DEPTH = BR * LD;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BRW   = (BR > 1) ? $clog2(BR) : 1;

  wmr_cmd_e          op;
  int                rm;
  int                arow [WIN];
  logic [WIN-1:0]    rok;
  logic [BRW-1:0]    brow [WIN];
  logic [WIN-1:0]    bok;
  logic [WIN-1:0]    bwe;
  logic [1:0]        wlane;
  logic [AW-1:0]     waddr;

  logic [DATA_W-1:0] b_max [WIN];
  logic [1:0]        b_off [WIN];
  logic [WIN-1:0]    b_any;
  logic [DATA_W-1:0] b_mid [WIN];

  logic [DATA_W-1:0] kval [WIN];
  logic [1:0]        koff [WIN];
  logic [WIN-1:0]    kok;
  logic [DATA_W-1:0] t_max;
  logic [1:0]        t_idx;
  logic              t_any;
  logic [RW-1:0]     n_row;
  logic [CW-1:0]     n_col;

  assign op = wmr_cmd_e'(cmd);

  // row steering: array row r belongs to bank r mod 3
  always_comb begin
    rm = int'(row_i) % 3;
    for (int k = 0; k < WIN; k++) begin
      arow[k] = int'(row_i) - 1 + k;
      rok[k]  = (arow[k] >= 0) && (arow[k] < ROWS);
    end
    for (int b = 0; b < WIN; b++) begin
      brow[b] = rok[(b - rm + 4) % 3] ? BRW'(arow[(b - rm + 4) % 3] / 3) : '0;
      bok[b]  = rok[(b - rm + 4) % 3];
      bwe[b]  = (op == CMD_WRITE) && (rm == b);
    end
    wlane = 2'(int'(col_i) % 3);
    waddr = AW'((int'(row_i) / 3) * LD + int'(col_i) / 3);
  end

  for (genvar b = 0; b < WIN; b++) begin : g_bank
    wmr_row_bank #(.DATA_W(DATA_W), .COLS(COLS), .BR(BR)) u_bank (
      .clk     (clk),
      .we      (bwe[b]),
      .wlane   (wlane),
      .waddr   (waddr),
      .wdata   (wdata),
      .brow    (brow[b]),
      .row_ok  (bok[b]),
      .col_c   (col_i),
      .row_max (b_max[b]),
      .row_off (b_off[b]),
      .row_any (b_any[b]),
      .mid_val (b_mid[b])
    );
  end

  // put bank winners back into window-row order (lowest row first)
  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      kval[k] = b_max[(rm + k + 2) % 3];
      koff[k] = b_off[(rm + k + 2) % 3];
      kok[k]  = b_any[(rm + k + 2) % 3];
    end
  end

  wmr_compete #(.N(WIN), .W(DATA_W)) u_top_cmp (
    .val  (kval),
    .ok   (kok),
    .best (t_max),
    .idx  (t_idx),
    .any  (t_any)
  );

  always_comb begin
    n_row = RW'(int'(row_i) - 1 + int'(t_idx));
    n_col = CW'(int'(col_i) - 1 + int'(koff[t_idx]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      win_valid <= 1'b0;
      rd_data   <= '0;
      win_max   <= '0;
      win_row   <= '0;
      win_col   <= '0;
    end else begin
      rd_valid  <= (op == CMD_READ);
      win_valid <= (op == CMD_SEARCH) && t_any;
      if (op == CMD_READ) rd_data <= b_mid[rm];
      if (op == CMD_SEARCH) begin
        win_max <= t_max;
        win_row <= n_row;
        win_col <= n_col;
      end
    end
  end
endmodule

// File: rtl/wmr_checker.sv
module wmr_checker #(
  parameter int DATA_W = 8,
  parameter int ROWS   = 12,
  parameter int COLS   = 16,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cmd,
  input logic [RW-1:0]     row_i,
  input logic [CW-1:0]     col_i,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              win_valid,
  input logic [DATA_W-1:0] win_max,
  input logic [RW-1:0]     win_row,
  input logic [CW-1:0]     win_col
);
  assert_read_valid_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd2) |=> rd_valid);

  assert_write_forward_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd2 && $past(cmd) == 2'd1 && $past(row_i) == row_i && $past(col_i) == col_i)
      |=> (rd_data == $past(wdata, 2)));

  assert_search_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd3 && int'(row_i) < ROWS && int'(col_i) < COLS) |=> win_valid);

  assert_loc_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((int'(win_row) + 1 >= int'($past(row_i))) && (int'(win_row) <= int'($past(row_i)) + 1)
                && (int'(win_col) + 1 >= int'($past(col_i))) && (int'(win_col) <= int'($past(col_i)) + 1)));

  assert_loc_in_array_R5: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((int'(win_row) < ROWS) && (int'(win_col) < COLS)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd0 || cmd == 2'd1) |=> (!rd_valid && !win_valid));

  assert_one_result_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, win_valid}));
endmodule

bind win_max_ram wmr_checker #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .row_i     (row_i),
  .col_i     (col_i),
  .wdata     (wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .win_valid (win_valid),
  .win_max   (win_max),
  .win_row   (win_row),
  .win_col   (win_col)
);

// File: tb/win_max_ram_test.sv
module win_max_ram_test;
  localparam int DATA_W = 8;
  localparam int ROWS   = 12;
  localparam int COLS   = 16;
  localparam int RW     = $clog2(ROWS);
  localparam int CW     = $clog2(COLS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cmd = 2'd0;
  logic [RW-1:0]     row_i = '0;
  logic [CW-1:0]     col_i = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              rd_valid, win_valid;
  logic [DATA_W-1:0] rd_data, win_max;
  logic [RW-1:0]     win_row;
  logic [CW-1:0]     win_col;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DATA_W-1:0] mdl [ROWS][COLS];

  always #4 clk = ~clk;

  win_max_ram #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rst(rst), .cmd(cmd), .row_i(row_i), .col_i(col_i), .wdata(wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .win_valid(win_valid),
    .win_max(win_max), .win_row(win_row), .win_col(win_col));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // row-major scan with strict greater: lowest row, then lowest column wins ties
  task automatic expect_win(input int r, input int c, output int ev, output int er, output int ec);
    bit found = 0;
    ev = 0; er = 0; ec = 0;
    for (int dr = 0; dr < 3; dr++)
      for (int dc = 0; dc < 3; dc++) begin
        int ar = r - 1 + dr;
        int ac = c - 1 + dc;
        if (ar >= 0 && ar < ROWS && ac >= 0 && ac < COLS)
          if (!found || int'(mdl[ar][ac]) > ev) begin
            found = 1; ev = int'(mdl[ar][ac]); er = ar; ec = ac;
          end
      end
  endtask

  task automatic op(input int c, input int r, input int col, input int d, input string tag);
    int ev, er, ec;
    cmd = 2'(c); row_i = RW'(r); col_i = CW'(col); wdata = DATA_W'(d);
    if (c == 1) mdl[r][col] = DATA_W'(d);
    @(negedge clk);
    case (c)
      0, 1: begin
        check({tag, " R7 rd_valid"}, int'(rd_valid), 0);
        check({tag, " R7 win_valid"}, int'(win_valid), 0);
      end
      2: begin
        check({tag, " R1 rd_valid"}, int'(rd_valid), 1);
        check({tag, " R1 rd_data"}, int'(rd_data), int'(mdl[r][col]));
      end
      default: begin
        expect_win(r, col, ev, er, ec);
        check({tag, " R2 win_valid"}, int'(win_valid), 1);
        check({tag, " R2 win_max"}, int'(win_max), ev);
        check({tag, " R3 win_row"}, int'(win_row), er);
        check({tag, " R3 win_col"}, int'(win_col), ec);
      end
    endcase
  endtask

  task automatic clear_window(input int r, input int c);
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (r + dr >= 0 && r + dr < ROWS && c + dc >= 0 && c + dc < COLS)
          op(1, r + dr, c + dc, 0, "clr");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R7 reset rd_valid", int'(rd_valid), 0);
    check("R7 reset win_valid", int'(win_valid), 0);
    rst = 1'b0;
    // fill array
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) op(1, r, c, int'($urandom % 256), "fill");
    op(0, 0, 0, 0, "R7 nop");
    // R1 write then immediate read
    op(1, 7, 11, 8'hA5, "R1 wr");
    op(2, 7, 11, 0, "R1 rd-after-wr");
    for (int i = 0; i < 40; i++) op(2, int'($urandom % ROWS), int'($urandom % COLS), 0, "R1 rand rd");
    // R5 all-zero corner windows
    clear_window(0, 0);
    op(3, 0, 0, 0, "R5 corner00 zeros");
    clear_window(ROWS - 1, COLS - 1);
    op(3, ROWS - 1, COLS - 1, 0, "R5 far corner zeros");
    op(3, 0, COLS - 1, 0, "R5 top-right");
    op(3, ROWS - 1, 0, 0, "R5 bottom-left");
    // R4 ties across rows and within a row
    clear_window(5, 8);
    op(1, 5, 7, 200, "R4 set");
    op(1, 4, 9, 200, "R4 set");
    op(3, 5, 8, 0, "R4 tie rows");
    op(1, 4, 9, 0, "R4 set");
    op(1, 5, 9, 200, "R4 set");
    op(3, 5, 8, 0, "R4 tie cols");
    op(1, 6, 7, 255, "R2 set");
    op(3, 5, 8, 0, "R2 max bottom row");
    // R6 back-to-back searches mixed with random writes and reads, small values for ties
    for (int i = 0; i < 400; i++) begin
      int k = int'($urandom % 4);
      int r = int'($urandom % ROWS);
      int c = int'($urandom % COLS);
      if (k == 0) op(1, r, c, int'($urandom % 4) * 60, "R6 rand wr");
      else if (k == 1) op(2, r, c, 0, "R6 rand rd");
      else op(3, r, c, 0, "R6 rand search");
    end
    for (int i = 0; i < 20; i++) op(3, i % ROWS, (i * 5) % COLS, 0, "R6 streak");
    op(0, 0, 0, 0, "R7 tail nop");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule